// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the part of a small 8-bit CPU core that moves machine state between the register file and the stack when control passes into or out of a handler. When an interrupt is accepted at an instruction boundary, it writes a nine-byte frame through a byte-wide memory write port. It then reads a 16-bit handler address from a vector table at the top of the address space and hands that address to the core as the new program counter. A return request reverses the process. It reads the frame back, starting with the last byte written, and returns every register, the stack pointer and the program counter to the core.

A wait request stacks the frame at once, before any interrupt is pending. The block then idles until the arbiter presents a request, and goes straight to the vector fetch. Leaving reset takes the same vector fetch for source 0, but no frame is written. While the block is stacking, unstacking, waiting or fetching a vector, `busy_o` holds the instruction fetcher. The arbiter supplies the accepted source index and only presents requests that are unmasked.

Top module: `irq_seq`

## Requirements
- R1: After `rst_ni` is released, the block writes nothing. It reads 0xFFFE and then 0xFFFF, and then pulses `pc_load_o` and `mask_set_o` with `pc_o` = {byte at 0xFFFE, byte at 0xFFFF}. `sp_load_o` stays low. While reset is held, `busy_o` is 1 and both memory strobes are 0.
- R2: An interrupt is accepted only in an idle cycle where `insn_done_i` and `irq_valid_i` are both high. `irq_valid_i` with `insn_done_i` low starts nothing.
- R3: On acceptance, nine consecutive write cycles follow, at addresses SP, SP-1, ..., SP-8, where SP is `sp_i` in the accepting cycle. The bytes are written in this order: PC low, PC high, IY low, IY high, IX low, IX high, A, B, CCR. All values are those on the inputs in the accepting cycle.
- R4: The vector for source k is read from address 0xFFFE-2k, which holds the high byte, and then from 0xFFFF-2k, which holds the low byte. The reads take two consecutive cycles.
- R5: After the vector reads, one cycle pulses `pc_load_o`, `mask_set_o` and `sp_load_o` together, with `sp_o` = SP-9. The next cycle is idle. An interrupt entry holds `busy_o` high for 12 cycles.
- R6: A return request reads nine consecutive bytes at SP+1 up to SP+9. The byte at SP+1 is CCR, then B, then A, then IX high, IX low, IY high, IY low, PC high and PC low. One cycle then pulses `regs_load_o`, `pc_load_o` and `sp_load_o` with the restored values and `sp_o` = SP+9, and `mask_set_o` stays low. `busy_o` is high for 10 cycles.
- R7: A wait request stacks the frame as in R3 without needing `insn_done_i`. The block then holds `busy_o` high with no memory access until `irq_valid_i` is seen. It then reads the vector of `irq_src_i` as in R4 and completes as in R5.
- R8: If requests arrive in the same idle cycle, a return takes precedence over a wait, and a wait takes precedence over an interrupt.
- R9: `busy_o` is high in every non-idle cycle. Any request that arrives while `busy_o` is high is ignored.
- R10: No cycle asserts both `mem_we_o` and `mem_re_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| insn_done_i | input | 1 | Current instruction has completed |
| irq_valid_i | input | 1 | Arbiter presents an unmasked request |
| irq_src_i | input | 5 | Accepted source index |
| rti_req_i | input | 1 | Return-from-interrupt request |
| wai_req_i | input | 1 | Wait-for-interrupt request |
| pc_i | input | 16 | Current program counter |
| iy_i | input | 16 | Index register Y |
| ix_i | input | 16 | Index register X |
| a_i | input | 8 | Accumulator A |
| b_i | input | 8 | Accumulator B |
| ccr_i | input | 8 | Condition-code register |
| sp_i | input | 16 | Current stack pointer |
| mem_rdata_i | input | 8 | Read data (same cycle as address) |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe |
| pc_o | output | 16 | New program counter |
| pc_load_o | output | 1 | Load `pc_o` |
| mask_set_o | output | 1 | Set the interrupt mask bit in the live CCR |
| sp_o | output | 16 | New stack pointer |
| sp_load_o | output | 1 | Load `sp_o` |
| iy_o | output | 16 | Restored IY |
| ix_o | output | 16 | Restored IX |
| a_o | output | 8 | Restored A |
| b_o | output | 8 | Restored B |
| ccr_o | output | 8 | Restored CCR |
| regs_load_o | output | 1 | Load restored registers |
| busy_o | output | 1 | Stall the instruction fetcher |

## Verification
Each interrupt entry uses its own register pattern, so that a swapped byte or a swapped half of a 16-bit register shows up at a distinct write address. A return then reads that same frame back, which checks that the pull order is the exact reverse of the push order and that the stack pointer ends where it started. Source indices 0, 5 and 31 test the table ends and an interior entry. This separates an off-by-one stride from a wrong byte order. Wait entry, simultaneous requests and a return request raised in the middle of stacking show apart the precedence rule, the idle wait with no memory traffic, and the rule that requests are ignored while busy.

// File: rtl/irq_seq_pkg.sv
`timescale 1ns/1ps
package irq_seq_pkg;
  localparam int FRAME_BYTES = 9;
  localparam int IDX_W = $clog2(FRAME_BYTES);

  typedef enum logic [3:0] {
    S_BOOT, S_IDLE, S_PUSH, S_WAIT, S_VHI, S_VLO, S_LOAD, S_PULL, S_REST
  } seq_state_e;
endpackage

// File: rtl/irq_seq_ctrl.sv
`timescale 1ns/1ps
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             insn_done_i,
  input  logic             irq_valid_i,
  input  logic             rti_req_i,
  input  logic             wai_req_i,
  output seq_state_e       state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             stacked_o,
  output logic             snap_o,
  output logic             sp_start_o,
  output logic             src_load_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BYTES - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic             wai_q, stacked_q;
  logic             idle, start_pull, start_push, take_irq, wake;

  assign idle       = (state_q == S_IDLE);
  assign start_pull = idle && rti_req_i;
  assign take_irq   = idle && !rti_req_i && !wai_req_i && insn_done_i && irq_valid_i;
  assign start_push = idle && !rti_req_i && (wai_req_i || (insn_done_i && irq_valid_i));
  assign wake       = (state_q == S_WAIT) && irq_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_BOOT: state_d = S_VHI;
      S_IDLE: if (start_pull) state_d = S_PULL;
              else if (start_push) state_d = S_PUSH;
      S_PUSH: if (idx_q == LAST) state_d = wai_q ? S_WAIT : S_VHI;
      S_WAIT: if (wake) state_d = S_VHI;
      S_VHI:  state_d = S_VLO;
      S_VLO:  state_d = S_LOAD;
      S_LOAD: state_d = S_IDLE;
      S_PULL: if (idx_q == LAST) state_d = S_REST;
      S_REST: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_BOOT;
      idx_q     <= '0;
      wai_q     <= 1'b0;
      stacked_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_PUSH || state_q == S_PULL)
        idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
      if (start_push) begin
        wai_q     <= wai_req_i;
        stacked_q <= 1'b1;
      end
    end
  end

  assign state_o    = state_q;
  assign idx_o      = idx_q;
  assign stacked_o  = stacked_q;
  assign snap_o     = start_push;
  assign sp_start_o = start_push || start_pull;
  assign src_load_o = take_irq || wake;
endmodule

// File: rtl/irq_seq_frame.sv
`timescale 1ns/1ps
module irq_seq_frame #(
  parameter int DW = 8,
  parameter int NB = 9,
  parameter int IW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          snap_i,
  input  logic [2*DW-1:0] pc_i,
  input  logic [2*DW-1:0] iy_i,
  input  logic [2*DW-1:0] ix_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] ccr_i,
  input  logic          cap_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] byte_o,
  output logic [2*DW-1:0] pc_o,
  output logic [2*DW-1:0] iy_o,
  output logic [2*DW-1:0] ix_o,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o,
  output logic [DW-1:0] ccr_o
);
  // slot i is the byte pushed i-th; pull step j refills slot NB-1-j
  logic [DW-1:0] slot_q [NB];
  logic [DW-1:0] snap_v [NB];

  assign snap_v[0] = pc_i[DW-1:0];
  assign snap_v[1] = pc_i[2*DW-1:DW];
  assign snap_v[2] = iy_i[DW-1:0];
  assign snap_v[3] = iy_i[2*DW-1:DW];
  assign snap_v[4] = ix_i[DW-1:0];
  assign snap_v[5] = ix_i[2*DW-1:DW];
  assign snap_v[6] = a_i;
  assign snap_v[7] = b_i;
  assign snap_v[8] = ccr_i;

  for (genvar g = 0; g < NB; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[g] <= '0;
      else if (snap_i) slot_q[g] <= snap_v[g];
      else if (cap_i && (IW'(NB - 1) - idx_i) == IW'(g)) slot_q[g] <= rdata_i;
    end
  end

  assign byte_o = slot_q[idx_i];
  assign pc_o   = {slot_q[1], slot_q[0]};
  assign iy_o   = {slot_q[3], slot_q[2]};
  assign ix_o   = {slot_q[5], slot_q[4]};
  assign a_o    = slot_q[6];
  assign b_o    = slot_q[7];
  assign ccr_o  = slot_q[8];
endmodule

// File: rtl/irq_seq_vec.sv
`timescale 1ns/1ps
module irq_seq_vec #(
  parameter int          AW    = 16,
  parameter int          SW    = 5,
  parameter logic [AW-1:0] TOP = 16'hFFFE
) (
  input  logic [SW-1:0] src_i,
  input  logic          lo_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] base;
  assign base   = TOP - (AW'(src_i) << 1);
  assign addr_o = lo_i ? (base | AW'(1)) : base;
endmodule

// File: rtl/irq_seq.sv
`timescale 1ns/1ps
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int            DATA_W    = 8,
  parameter int            ADDR_W    = 16,
  parameter int            N_SRC     = 32,
  parameter logic [15:0]   VEC_TOP   = 16'hFFFE,
  parameter int            RESET_SRC = 0,
  localparam int           SRC_W     = $clog2(N_SRC),
  localparam int           RW        = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              insn_done_i,
  input  logic              irq_valid_i,
  input  logic [SRC_W-1:0]  irq_src_i,
  input  logic              rti_req_i,
  input  logic              wai_req_i,
  input  logic [RW-1:0]     pc_i,
  input  logic [RW-1:0]     iy_i,
  input  logic [RW-1:0]     ix_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] ccr_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [RW-1:0]     pc_o,
  output logic              pc_load_o,
  output logic              mask_set_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              sp_load_o,
  output logic [RW-1:0]     iy_o,
  output logic [RW-1:0]     ix_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o,
  output logic [DATA_W-1:0] ccr_o,
  output logic              regs_load_o,
  output logic              busy_o
);
  seq_state_e         state;
  logic [IDX_W-1:0]   idx;
  logic               stacked, snap, sp_start, src_load;
  logic [ADDR_W-1:0]  sp_q, vec_addr;
  logic [SRC_W-1:0]   src_q;
  logic [DATA_W-1:0]  vhi_q, vlo_q;
  logic [RW-1:0]      frame_pc;

  irq_seq_ctrl u_ctrl (
    .clk_i, .rst_ni, .insn_done_i, .irq_valid_i, .rti_req_i, .wai_req_i,
    .state_o(state), .idx_o(idx), .stacked_o(stacked), .snap_o(snap),
    .sp_start_o(sp_start), .src_load_o(src_load)
  );

  irq_seq_frame #(.DW(DATA_W), .NB(FRAME_BYTES), .IW(IDX_W)) u_frame (
    .clk_i, .rst_ni, .snap_i(snap), .pc_i, .iy_i, .ix_i, .a_i, .b_i, .ccr_i,
    .cap_i(state == S_PULL), .idx_i(idx), .rdata_i(mem_rdata_i),
    .byte_o(mem_wdata_o), .pc_o(frame_pc), .iy_o, .ix_o, .a_o, .b_o, .ccr_o
  );

  irq_seq_vec #(.AW(ADDR_W), .SW(SRC_W), .TOP(ADDR_W'(VEC_TOP))) u_vec (
    .src_i(src_q), .lo_i(state == S_VLO), .addr_o(vec_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      src_q <= SRC_W'(RESET_SRC);
      vhi_q <= '0;
      vlo_q <= '0;
    end else begin
      if (sp_start)              sp_q <= sp_i;
      else if (state == S_PUSH)  sp_q <= sp_q - ADDR_W'(1);
      else if (state == S_PULL)  sp_q <= sp_q + ADDR_W'(1);
      if (src_load)              src_q <= irq_src_i;
      if (state == S_VHI)        vhi_q <= mem_rdata_i;
      if (state == S_VLO)        vlo_q <= mem_rdata_i;
    end
  end

  always_comb begin
    unique case (state)
      S_PUSH:       mem_addr_o = sp_q;
      S_PULL:       mem_addr_o = sp_q + ADDR_W'(1);
      S_VHI, S_VLO: mem_addr_o = vec_addr;
      default:      mem_addr_o = '0;
    endcase
  end

  assign mem_we_o    = (state == S_PUSH);
  assign mem_re_o    = (state == S_VHI) || (state == S_VLO) || (state == S_PULL);
  assign pc_load_o   = (state == S_LOAD) || (state == S_REST);
  assign pc_o        = (state == S_LOAD) ? {vhi_q, vlo_q} : frame_pc;
  assign mask_set_o  = (state == S_LOAD);
  assign regs_load_o = (state == S_REST);
  assign sp_load_o   = ((state == S_LOAD) && stacked) || (state == S_REST);
  assign sp_o        = sp_q;
  assign busy_o      = (state != S_IDLE);
endmodule

// File: rtl/irq_seq_chk.sv
`timescale 1ns/1ps
module irq_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic              pc_load_o,
  input logic              mask_set_o,
  input logic              sp_load_o,
  input logic              regs_load_o,
  input logic              busy_o
);
  a_r10_no_we_and_re: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  a_r3_push_descends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && $past(mem_we_o) |-> mem_addr_o == $past(mem_addr_o) - ADDR_W'(1));

  a_r4_read_ascends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o && $past(mem_re_o) |-> mem_addr_o == $past(mem_addr_o) + ADDR_W'(1));

  a_r5_idle_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> !busy_o);

  a_r5_mask_with_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_set_o |-> pc_load_o && !regs_load_o);

  a_r6_restore_bundle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_load_o |-> pc_load_o && sp_load_o && !mask_set_o);

  a_r9_access_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o || pc_load_o) |-> busy_o);

  a_r9_busy_ends_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(pc_load_o));
endmodule

bind irq_seq irq_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_irq_seq.sv
`timescale 1ns/1ps
module sim_irq_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic insn_done = 0, irq_valid = 0, rti_req = 0, wai_req = 0;
  logic [4:0]  irq_src = '0;
  logic [15:0] pc_in = '0, iy_in = '0, ix_in = '0, sp_in = '0;
  logic [7:0]  a_in = '0, b_in = '0, ccr_in = '0;
  logic [7:0]  rdata;
  logic [15:0] addr, pc_out, sp_out, iy_out, ix_out;
  logic [7:0]  wdata, a_out, b_out, ccr_out;
  logic we, re, pc_ld, mask_set, sp_ld, regs_ld, busy;

  logic [7:0] mem [0:4095];
  assign rdata = mem[addr[11:0]];

  irq_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .insn_done_i(insn_done), .irq_valid_i(irq_valid),
    .irq_src_i(irq_src), .rti_req_i(rti_req), .wai_req_i(wai_req),
    .pc_i(pc_in), .iy_i(iy_in), .ix_i(ix_in), .a_i(a_in), .b_i(b_in), .ccr_i(ccr_in),
    .sp_i(sp_in), .mem_rdata_i(rdata), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_we_o(we), .mem_re_o(re), .pc_o(pc_out), .pc_load_o(pc_ld),
    .mask_set_o(mask_set), .sp_o(sp_out), .sp_load_o(sp_ld), .iy_o(iy_out),
    .ix_o(ix_out), .a_o(a_out), .b_o(b_out), .ccr_o(ccr_out),
    .regs_load_o(regs_ld), .busy_o(busy)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int wn, rn, busy_n, done_n;
  logic [15:0] wr_a [16];
  logic [7:0]  wr_d [16];
  logic [15:0] rd_a [16];
  logic [15:0] g_pc, g_sp, g_iy, g_ix;
  logic [7:0]  g_a, g_b, g_ccr;
  logic g_mask, g_spld, g_regs;

  always @(negedge clk) if (rst_n) begin
    if (busy) busy_n++;
    if (we) begin
      mem[addr[11:0]] = wdata;
      if (wn < 16) begin wr_a[wn] = addr; wr_d[wn] = wdata; end
      wn++;
    end
    if (re) begin
      if (rn < 16) rd_a[rn] = addr;
      rn++;
    end
    if (pc_ld) begin
      g_pc = pc_out; g_sp = sp_out; g_mask = mask_set; g_spld = sp_ld; g_regs = regs_ld;
      g_iy = iy_out; g_ix = ix_out; g_a = a_out; g_b = b_out; g_ccr = ccr_out;
      done_n++;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    wn = 0; rn = 0; busy_n = 0; done_n = 0;
    g_mask = 0; g_spld = 0; g_regs = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 80 && done_n == 0; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_regs(input logic [15:0] pc, iy, ix, sp, input logic [7:0] a, b, c);
    pc_in = pc; iy_in = iy; ix_in = ix; sp_in = sp; a_in = a; b_in = b; ccr_in = c;
  endtask

  task automatic check_frame(input string req, input logic [15:0] sp);
    logic [7:0] exp [9];
    exp[0] = pc_in[7:0]; exp[1] = pc_in[15:8]; exp[2] = iy_in[7:0]; exp[3] = iy_in[15:8];
    exp[4] = ix_in[7:0]; exp[5] = ix_in[15:8]; exp[6] = a_in; exp[7] = b_in; exp[8] = ccr_in;
    chk(req, "write count", wn, 9);
    for (int i = 0; i < 9; i++) begin
      chk(req, "push addr", wr_a[i], sp - 16'(i));
      chk(req, "push byte", wr_d[i], exp[i]);
    end
  endtask

  task automatic check_vec(input string req, input int k, input int base);
    logic [15:0] va;
    va = 16'hFFFE - 16'(2 * k);
    chk(req, "vec hi addr", rd_a[base], va);
    chk(req, "vec lo addr", rd_a[base+1], va + 16'd1);
    chk(req, "pc from vector", g_pc, {mem[va[11:0]], mem[va[11:0] + 12'd1]});
  endtask

  task automatic t_reset();
    clear_logs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", busy, 1);
    chk("R1", "strobes in reset", {we, re}, 0);
    rst_n = 1;
    wait_done();
    chk("R1", "writes", wn, 0);
    chk("R1", "reads", rn, 2);
    check_vec("R1", 0, 0);
    chk("R1", "mask set", g_mask, 1);
    chk("R1", "sp load", g_spld, 0);
    chk("R9", "idle after reset", busy, 0);
  endtask

  task automatic t_no_done();
    clear_logs();
    irq_valid = 1; irq_src = 5'd2;
    repeat (6) @(negedge clk);
    irq_valid = 0;
    @(negedge clk);
    chk("R2", "busy w/o done", busy_n, 0);
    chk("R2", "writes w/o done", wn, 0);
  endtask

  task automatic t_irq(input int k, input logic poke_rti);
    logic [15:0] sp;
    sp = sp_in;
    clear_logs();
    insn_done = 1; irq_valid = 1; irq_src = 5'(k);
    @(negedge clk);
    insn_done = 0; irq_valid = 0;
    if (poke_rti) begin
      repeat (3) @(negedge clk);
      rti_req = 1; wai_req = 1;
      @(negedge clk);
      rti_req = 0; wai_req = 0;
    end
    wait_done();
    check_frame("R3", sp);
    chk("R4", "reads", rn, 2);
    check_vec("R4", k, 0);
    chk("R5", "mask", g_mask, 1);
    chk("R5", "sp load", g_spld, 1);
    chk("R5", "sp value", g_sp, sp - 16'd9);
    chk("R5", "busy cycles", busy_n, 12);
    chk("R9", "no restore", g_regs, 0);
    repeat (2) @(negedge clk);
    chk("R9", "late request ignored", busy, 0);
  endtask

  task automatic t_rti(input logic [15:0] sp0, input logic [15:0] pc, iy, ix,
                       input logic [7:0] a, b, c, input logic all_req);
    clear_logs();
    sp_in = sp0 - 16'd9;
    rti_req = 1;
    if (all_req) begin wai_req = 1; insn_done = 1; irq_valid = 1; end
    @(negedge clk);
    rti_req = 0; wai_req = 0; insn_done = 0; irq_valid = 0;
    wait_done();
    chk(all_req ? "R8" : "R6", "writes", wn, 0);
    chk("R6", "reads", rn, 9);
    for (int j = 0; j < 9; j++) chk("R6", "pull addr", rd_a[j], sp0 - 16'd8 + 16'(j));
    chk("R6", "regs load", g_regs, 1);
    chk("R6", "pc", g_pc, pc);
    chk("R6", "iy", g_iy, iy);
    chk("R6", "ix", g_ix, ix);
    chk("R6", "a/b/ccr", {g_a, g_b, g_ccr}, {a, b, c});
    chk("R6", "sp", g_sp, sp0);
    chk("R6", "no mask", g_mask, 0);
    chk("R6", "busy cycles", busy_n, 10);
  endtask

  task automatic t_wai(input int k, input logic with_irq);
    logic [15:0] sp;
    sp = sp_in;
    clear_logs();
    wai_req = 1;
    if (with_irq) begin insn_done = 1; irq_valid = 1; irq_src = 5'd9; end
    @(negedge clk);
    wai_req = 0; insn_done = 0; irq_valid = 0;
    repeat (16) @(negedge clk);
    check_frame(with_irq ? "R8" : "R7", sp);
    chk("R7", "no read while waiting", rn, 0);
    chk("R7", "busy while waiting", busy, 1);
    chk("R7", "no load while waiting", done_n, 0);
    irq_valid = 1; irq_src = 5'(k);
    @(negedge clk);
    irq_valid = 0;
    wait_done();
    chk("R7", "reads", rn, 2);
    check_vec("R7", k, 0);
    chk("R7", "sp", g_sp, sp - 16'd9);
    chk("R7", "mask", g_mask, 1);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    for (int k = 0; k < 32; k++) begin
      mem[12'hFFE - 12'(2 * k)] = 8'h40 + 8'(k);
      mem[12'hFFF - 12'(2 * k)] = 8'h10 + 8'(3 * k);
    end
    t_reset();
    t_no_done();
    set_regs(16'hA1B2, 16'hC3D4, 16'hE5F6, 16'h01F0, 8'h17, 8'h28, 8'h09);
    t_irq(5, 0);
    t_rti(16'h01F0, 16'hA1B2, 16'hC3D4, 16'hE5F6, 8'h17, 8'h28, 8'h09, 0);
    set_regs(16'h0F1E, 16'h2D3C, 16'h4B5A, 16'h0280, 8'h69, 8'h78, 8'hC0);
    t_irq(0, 0);
    set_regs(16'h1357, 16'h9BDF, 16'h2468, 16'h0400, 8'hAC, 8'hE0, 8'h55);
    t_irq(31, 1);
    t_rti(16'h0400, 16'h1357, 16'h9BDF, 16'h2468, 8'hAC, 8'hE0, 8'h55, 1);
    set_regs(16'h7766, 16'h5544, 16'h3322, 16'h0300, 8'h11, 8'h99, 8'h04);
    t_wai(3, 0);
    set_regs(16'h8899, 16'hAABB, 16'hCCDD, 16'h0500, 8'hEE, 8'hFF, 8'h01);
    t_wai(17, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule